// File: doc/BRIEF.md
# Five-Function ALU with Zero Flag

This block is the arithmetic-logic unit of a small load/store processor's datapath. It takes two operands and a 3-bit operation code. It returns a result word together with a flag that is high whenever that result is all zeros. It offers five functions: bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than. The other three codes yield a zero word.

The block is purely combinational and has no clock or reset. Addition, subtraction and the comparison all run through one adder. Subtraction feeds the adder with the inverted B operand and a carry-in of one. The comparison takes the sign of that difference and corrects it with the signed-overflow term, so operands far apart in value still compare correctly. The zero flag is produced for every code. The datapath uses it to resolve equality branches by subtracting one register from another.

Top module: `alu5_unit`

## Requirements
- R1: Code 3'b000 returns the bitwise AND of opnd_a and opnd_b.
- R2: Code 3'b001 returns the bitwise OR of opnd_a and opnd_b.
- R3: Code 3'b010 returns opnd_a plus opnd_b modulo 2^W. The carry out of the top bit is dropped.
- R4: Code 3'b110 returns opnd_a minus opnd_b modulo 2^W.
- R5: Code 3'b111 returns 1 in bit 0 when opnd_a is less than opnd_b as signed two's-complement numbers, and 0 otherwise. All higher bits are 0. The answer stays correct when the difference overflows.
- R6: zero_out is 1 exactly when all W bits of result are 0. This holds under every code, including the unused ones.
- R7: Codes 3'b011, 3'b100 and 3'b101 return a result of all zeros whatever the operands, so zero_out is 1 for them.
- R8: The outputs are a pure function of the present inputs. They follow an input change in the same time step, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W (32) | First operand |
| opnd_b | input | W (32) | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | W (32) | Operation result |
| zero_out | output | 1 | High when result is all zeros |

## Verification
The bench builds two copies of the block. One uses the default width of 32. The other uses a width of 5, which makes an exhaustive sweep practical: every operand pair under all eight codes. That sweep reaches every signed-overflow boundary of the comparison, every wrap of the sum and difference, and every input that drives the zero flag high. The 32-bit copy receives directed extreme values, such as the most negative number against the most positive, plus a long run of pseudo-random vectors. These show that the wide build behaves exactly like the narrow one.

// File: rtl/alu5_pkg.sv
package alu5_pkg;

  typedef enum logic [2:0] {
    OPC_AND = 3'b000,
    OPC_OR  = 3'b001,
    OPC_ADD = 3'b010,
    OPC_SUB = 3'b110,
    OPC_SLT = 3'b111
  } alu5_opc_e;

  // One-hot result path selects plus the adder's invert control.
  typedef struct packed {
    logic sel_and;
    logic sel_or;
    logic sel_sum;
    logic sel_slt;
    logic invert_b;
  } alu5_ctl_t;

  // Signed less-than from the sign bits of the operands and the difference:
  // differing operand signs decide directly, equal signs rely on the difference.
  function automatic logic signed_less(input logic a_msb, input logic b_msb,
                                       input logic diff_msb);
    logic ovf;
    ovf = (a_msb != b_msb) && (diff_msb != a_msb);
    return diff_msb ^ ovf;
  endfunction

endpackage

// File: rtl/alu5_opdec.sv
module alu5_opdec
  import alu5_pkg::*;
(
  input  logic [2:0] op_sel,
  output alu5_ctl_t  ctl,
  output logic       op_valid
);

  always_comb begin
    ctl      = '0;
    op_valid = 1'b1;
    case (op_sel)
      OPC_AND: ctl.sel_and = 1'b1;
      OPC_OR:  ctl.sel_or  = 1'b1;
      OPC_ADD: ctl.sel_sum = 1'b1;
      OPC_SUB: begin
        ctl.sel_sum  = 1'b1;
        ctl.invert_b = 1'b1;
      end
      OPC_SLT: begin
        ctl.sel_slt  = 1'b1;
        ctl.invert_b = 1'b1;
      end
      default: op_valid = 1'b0;
    endcase
  end

  always_comb begin
    AST_ONE_PATH: assert ($onehot0({ctl.sel_and, ctl.sel_or, ctl.sel_sum, ctl.sel_slt}))
      else $error("more than one result path selected"); // R7
    AST_VALID_HAS_PATH: assert (op_valid == (ctl.sel_and | ctl.sel_or | ctl.sel_sum | ctl.sel_slt))
      else $error("validity and path select disagree"); // R7
  end

endmodule

// File: rtl/alu5_addsub.sv
module alu5_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  output logic [W-1:0] sum,
  output logic         a_msb,
  output logic         b_msb,
  output logic         sum_msb
);

  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = invert_b ? ~b : b;
    sum   = a + b_eff + W'(invert_b);
  end

  assign a_msb   = a[W-1];
  assign b_msb   = b[W-1];
  assign sum_msb = sum[W-1];

  always_comb begin
    if (invert_b) begin
      AST_SUB_INVERSE: assert (W'(sum + b) == a)
        else $error("difference plus B does not restore A"); // R4
    end else begin
      AST_ADD_INVERSE: assert (W'(sum - b) == a)
        else $error("sum minus B does not restore A"); // R3
    end
  end

endmodule

// File: rtl/alu5_zero_det.sv
module alu5_zero_det #(
  parameter int W   = 32,
  parameter int GRP = 4
) (
  input  logic [W-1:0] res,
  output logic         is_zero
);

  localparam int GROUPS = (W + GRP - 1) / GRP;
  localparam int PADW   = GROUPS * GRP;

  logic [PADW-1:0]   padded;
  logic [GROUPS-1:0] group_any;

  always_comb begin
    padded        = '0;
    padded[W-1:0] = res;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign group_any[g] = |padded[g*GRP +: GRP];
  end

  assign is_zero = ~|group_any;

  always_comb begin
    AST_ZERO_FLAG: assert (is_zero == (res == '0))
      else $error("zero flag disagrees with result"); // R6
  end

endmodule

// File: rtl/alu5_unit.sv
module alu5_unit
  import alu5_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] result,
  output logic         zero_out
);

  alu5_ctl_t    ctl;
  logic         op_valid;
  logic [W-1:0] sum;
  logic         a_msb, b_msb, sum_msb;
  logic         less;

  alu5_opdec u_opdec (
    .op_sel  (op_sel),
    .ctl     (ctl),
    .op_valid(op_valid)
  );

  alu5_addsub #(.W(W)) u_addsub (
    .a       (opnd_a),
    .b       (opnd_b),
    .invert_b(ctl.invert_b),
    .sum     (sum),
    .a_msb   (a_msb),
    .b_msb   (b_msb),
    .sum_msb (sum_msb)
  );

  assign less = signed_less(a_msb, b_msb, sum_msb);

  // AND-OR result mux: an unused code selects no path and yields zero.
  always_comb begin
    result = ({W{ctl.sel_and}} & (opnd_a & opnd_b))
           | ({W{ctl.sel_or}}  & (opnd_a | opnd_b))
           | ({W{ctl.sel_sum}} & sum)
           | ({W{ctl.sel_slt}} & {{(W-1){1'b0}}, less});
  end

  alu5_zero_det #(.W(W)) u_zero (
    .res    (result),
    .is_zero(zero_out)
  );

  always_comb begin
    if (ctl.sel_slt) begin
      AST_SLT_BOOL: assert (result[W-1:1] == '0)
        else $error("comparison result wider than one bit"); // R5
    end
    if (!op_valid) begin
      AST_UNUSED_ZERO: assert (result == '0 && zero_out)
        else $error("unused code gave nonzero result"); // R7
    end
  end

endmodule

// File: tb/alu5_unit_tb.sv
module alu5_unit_tb;

  localparam int WW = 32;
  localparam int WS = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [WW-1:0] a_w, b_w, res_w;
  logic [WS-1:0] a_s, b_s, res_s;
  logic [2:0]    op_w, op_s;
  logic          z_w, z_s;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  alu5_unit #(.W(WW)) u_dut (
    .opnd_a(a_w), .opnd_b(b_w), .op_sel(op_w), .result(res_w), .zero_out(z_w)
  );

  alu5_unit #(.W(WS)) u_dut_small (
    .opnd_a(a_s), .opnd_b(b_s), .op_sel(op_s), .result(res_s), .zero_out(z_s)
  );

  function automatic longint ref_res(input int w, input logic [2:0] op,
                                     input longint a, input longint b);
    longint m, half, sa, sb;
    m    = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    sa   = (a >= half) ? a - (m + 1) : a;
    sb   = (b >= half) ? b - (m + 1) : b;
    case (op)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b010:  return (a + b) & m;
      3'b110:  return (a - b) & m;
      3'b111:  return (sa < sb) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run_wide(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint e;
    @(posedge clk);
    a_w = a; b_w = b; op_w = op;
    @(negedge clk);
    e = ref_res(WW, op, longint'(a), longint'(b));
    chk(req_of(op), longint'(res_w), e);
    chk("R6", longint'(z_w), (e == 0) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    a_w = '0; b_w = '0; op_w = 3'b000;
    a_s = '0; b_s = '0; op_s = 3'b000;
    @(negedge clk);
    // initial state: zero inputs, AND gives zero and raises the flag
    chk("R1", longint'(res_w), 0);
    chk("R6", longint'(z_w), 1);

    // R8: output follows an input change within the same time step
    @(negedge clk);
    a_w = 32'h0000_00F0; b_w = 32'h0000_0F0F; op_w = 3'b001;
    #1;
    chk("R8", longint'(res_w), 64'h0FFF);

    // directed 32-bit corner cases
    run_wide(3'b000, 32'hF0F0_F0F0, 32'h0FF0_0FF0);
    run_wide(3'b000, 32'hAAAA_AAAA, 32'h5555_5555);
    run_wide(3'b001, 32'hAAAA_AAAA, 32'h5555_5555);
    run_wide(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
    run_wide(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
    run_wide(3'b110, 32'h1234_5678, 32'h1234_5678);
    run_wide(3'b110, 32'h0000_0000, 32'h0000_0001);
    run_wide(3'b110, 32'h8000_0000, 32'h0000_0001);
    run_wide(3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
    run_wide(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
    run_wide(3'b111, 32'hFFFF_FFFF, 32'h0000_0000);
    run_wide(3'b111, 32'h0000_0005, 32'h0000_0005);
    run_wide(3'b111, 32'h0000_0004, 32'h0000_0005);
    run_wide(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_wide(3'b100, 32'h1234_5678, 32'h9ABC_DEF0);
    run_wide(3'b101, 32'h8000_0000, 32'h7FFF_FFFF);

    // pseudo-random 32-bit sweep over all codes
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra   = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_wide(3'(i % 8), ra, (i % 16 == 3) ? ra : lfsr);
    end

    // exhaustive 5-bit sweep: every operand pair under every code
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < (1 << WS); a++) begin
        for (int b = 0; b < (1 << WS); b++) begin
          longint e;
          @(posedge clk);
          a_s = WS'(a); b_s = WS'(b); op_s = 3'(op);
          @(negedge clk);
          e = ref_res(WS, 3'(op), longint'(a), longint'(b));
          chk(req_of(3'(op)), longint'(res_s), e);
          chk("R6", longint'(z_s), (e == 0) ? 1 : 0);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule